// File: doc/BRIEF.md
# Flash Line Buffer Prefetch Controller

This block sits between a word-wide bus read port and a slow flash array that delivers one whole line per fetch. It keeps a few line buffers, each with a line-address tag and a valid flag. A read whose line is held in a buffer is answered from that buffer without touching the flash. A read whose line is missing starts a line fetch, and the reply is taken from the returned line. Depending on the selected policy, a buffer hit may also start a fetch of the following line, so that sequential code finds its next line already buffered.

Two configuration inputs steer the block. A 2-bit policy field selects one of three policies: no buffering at all, fill on miss only, or fill on miss plus a look-ahead fetch on hit. A buffer-enable bit lets the buffers answer reads; while it is low, every valid flag is wiped. Both settings are captured in a register that reset clears. The flash port has a single fetch channel. A demand miss that arrives while a look-ahead fetch is running waits for that fetch to end, and takes its line when it is the wanted one.

Top module: `lbuf_prefetch_ctrl`

## Requirements
- R1: With policy code 2'b00, every read starts exactly one line fetch and nothing is kept, so repeated reads of one line each fetch again.
- R2: With policy code 2'b01 and buffers enabled, a miss fills a buffer, a later read of that line is answered with no fetch, and a hit never starts a fetch.
- R3: With policy code 2'b10 or 2'b11 and buffers enabled, a hit on line L starts one fetch of line L+1 when L+1 is not held and the fetch channel is idle.
- R4: Under the look-ahead policy, a hit whose next line is already held starts no fetch, and a miss fetches only its own line.
- R5: A miss on the line a running look-ahead fetch is bringing in issues no second fetch and is answered with the word from that returned line.
- R6: While the buffer-enable bit is low, no read is answered from a buffer, and every buffer is invalid once it rises again.
- R7: Reset clears every buffer and the configuration register (policy off, buffers disabled), and leaves rd_ready and fl_req low.
- R8: rd_ready rises one cycle after a hit is accepted, or one cycle after the fl_done that completes a miss, and rd_data holds the word selected by the low rd_addr bits (word index = rd_addr[1:0] of the 4 words in a line, word 0 in line bits 31:0).
- R9: rd_ready is a one-cycle pulse. The requester holds rd_req and rd_addr until it sees that pulse.
- R10: Once raised, fl_req and fl_line_addr stay unchanged until the cycle in which fl_done is high.
- R11: A fill uses an invalid buffer if there is one. Otherwise it replaces the least recently used buffer, where both hits and fills count as use.
- R12: A miss on a different line while a look-ahead fetch runs waits for that fetch, then issues its own fetch, and is answered from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pf_mode | input | 2 | Policy: 00 none, 01 fill on miss, 1x also look ahead on hit |
| cfg_buf_en | input | 1 | Lets buffers answer reads; low wipes all valid flags |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | ADDR_W (14) | Word address: line number above, word index in the low 2 bits |
| rd_ready | output | 1 | One-cycle reply strobe |
| rd_data | output | WORD_W (32) | Read word, valid with rd_ready |
| fl_req | output | 1 | Line fetch request, held until fl_done |
| fl_line_addr | output | TAG_W (12) | Line number being fetched |
| fl_done | input | 1 | Fetch complete, one cycle, line data valid |
| fl_line | input | LINE_W (128) | Fetched line data |

## Verification
Each policy is tried with repeated reads of one line, which separates fetching on every read from serving out of a buffer. Walks across consecutive lines show whether the look-ahead targets L+1 and whether it is skipped when L+1 is already held. Back-to-back reads issued while a look-ahead is in flight, once to the same line and once to an unrelated line, tell the merged reply apart from a second fetch. A five-line pattern over four buffers with one line re-touched shows whether the least recently used line is the one evicted. Toggling enable and pulsing reset show whether held lines are forgotten.

// File: rtl/lbuf_pkg.sv
// Shared types and policy decoding for the line buffer prefetch controller.
// Assumes the policy field is two bits wide, with bit 1 meaning look ahead on hit.
package lbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_WAITPF = 2'd2
    } ctrl_state_t;

    // True when the policy keeps fetched lines in the buffers.
    function automatic logic policy_buffers(input logic [1:0] mode, input logic en);
        return en && (mode != 2'b00);
    endfunction

    // True when the policy starts a look-ahead fetch on a hit.
    function automatic logic policy_hit_lookahead(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/lbuf_cfg_reg.sv
// Configuration register: captures policy and enable inputs, cleared by reset.
// Assumes the inputs are quasi-static; changes take effect one cycle later.
module lbuf_cfg_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    input  logic       en_in,
    output logic [1:0] mode_q,
    output logic       en_q
);
    // Register the settings, resetting to policy off and buffers disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            en_q   <= 1'b0;
        end else begin
            mode_q <= mode_in;
            en_q   <= en_in;
        end
    end
endmodule

// File: rtl/lbuf_line_store.sv
// Line buffer storage: tags, valid flags and line data for NUM_BUF entries.
// Provides a demand lookup, a look-ahead probe and the first free entry.
// Assumes at most one fill per cycle; clear_all wins over a fill.
module lbuf_line_store #(
    parameter int NUM_BUF = 4,
    parameter int TAG_W   = 12,
    parameter int LINE_W  = 128,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [TAG_W-1:0]  probe_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_data,
    output logic              look_hit,
    output logic [LINE_W-1:0] look_line,
    output logic [IDX_W-1:0]  look_idx,
    output logic              probe_hit,
    output logic              free_any,
    output logic [IDX_W-1:0]  free_idx,
    output logic [NUM_BUF-1:0] valid_vec
);
    logic [TAG_W-1:0]  tag_q   [NUM_BUF];
    logic [LINE_W-1:0] line_q  [NUM_BUF];
    logic [NUM_BUF-1:0] valid_q;
    logic [NUM_BUF-1:0] match_look;
    logic [NUM_BUF-1:0] match_probe;

    // Per-entry tag comparators for the demand and look-ahead addresses.
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
        assign match_look[g]  = valid_q[g] && (tag_q[g] == look_tag);
        assign match_probe[g] = valid_q[g] && (tag_q[g] == probe_tag);
    end

    // Valid flags and tags: reset and clear wipe, a fill marks its entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_BUF; i++) begin
                if (clear_all) begin
                    valid_q[i] <= 1'b0;
                end else if (fill_en && (fill_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= fill_tag;
                end
            end
        end
    end

    // Line data written on fill; no reset needed since valid guards it.
    always_ff @(posedge clk) begin
        if (fill_en && !clear_all) begin
            line_q[fill_idx] <= fill_data;
        end
    end

    // Encode the matching entry and the lowest invalid entry.
    always_comb begin
        look_idx = '0;
        free_idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (match_look[i]) look_idx = IDX_W'(i);
            if (!valid_q[i])   free_idx = IDX_W'(i);
        end
    end

    assign look_hit  = |match_look;
    assign probe_hit = |match_probe;
    assign free_any  = ~&valid_q;
    assign look_line = line_q[look_idx];
    assign valid_vec = valid_q;
endmodule

// File: rtl/lbuf_lru.sv
// Least-recently-used order kept as a permutation of per-entry ages.
// Age 0 is most recent; the entry at age NUM_BUF-1 is the victim.
// Assumes at most one touch per cycle.
module lbuf_lru #(
    parameter int NUM_BUF = 4,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] age_q [NUM_BUF];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    // Move the touched entry to age 0 and age every younger entry by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_enCheck()) begin
            for (int i = 0; i < NUM_BUF; i++) begin
                if (touch_idx == IDX_W'(i))       age_q[i] <= '0;
                else if (age_q[i] < touched_age)  age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    function automatic logic touch_enCheck();
        return touch_en;
    endfunction

    // Find the oldest entry.
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (age_q[i] == IDX_W'(NUM_BUF - 1)) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lbuf_prefetch_ctrl.sv
// Flash line buffer prefetch controller (top).
// Serves word reads from line buffers, fetches missing lines over a single
// flash channel, and optionally looks ahead one line on a hit.
// Assumes: requester holds rd_req/rd_addr until rd_ready; flash holds
// nothing of its own and pulses fl_done for one cycle with fl_line valid.
module lbuf_prefetch_ctrl #(
    parameter int ADDR_W  = 14,
    parameter int WORD_W  = 32,
    parameter int LINE_W  = 128,
    parameter int NUM_BUF = 4,
    localparam int WSEL_W = $clog2(LINE_W / WORD_W),
    localparam int TAG_W  = ADDR_W - WSEL_W,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_pf_mode,
    input  logic              cfg_buf_en,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [WORD_W-1:0] rd_data,
    output logic              fl_req,
    output logic [TAG_W-1:0]  fl_line_addr,
    input  logic              fl_done,
    input  logic [LINE_W-1:0] fl_line
);
    import lbuf_pkg::*;

    logic [1:0]        mode_q;
    logic              en_q;
    ctrl_state_t       state_q;
    logic [TAG_W-1:0]  dem_line_q;
    logic [WSEL_W-1:0] dem_word_q;

    logic [TAG_W-1:0]  req_line;
    logic [WSEL_W-1:0] req_word;
    logic              buf_on;
    logic              look_hit, probe_hit, free_any;
    logic [LINE_W-1:0] look_line;
    logic [IDX_W-1:0]  look_idx, free_idx, lru_idx, victim_idx;
    logic [NUM_BUF-1:0] valid_vec;
    logic              accept, hit_accept, miss_accept, pf_start;
    logic              fetch_done, fill_fire, touch_en;
    logic [IDX_W-1:0]  touch_idx;

    lbuf_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (cfg_pf_mode),
        .en_in   (cfg_buf_en),
        .mode_q  (mode_q),
        .en_q    (en_q)
    );

    assign req_line = rd_addr[ADDR_W-1:WSEL_W];
    assign req_word = rd_addr[WSEL_W-1:0];
    assign buf_on   = policy_buffers(mode_q, en_q);

    lbuf_line_store #(.NUM_BUF(NUM_BUF), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (!en_q),
        .look_tag  (req_line),
        .probe_tag (req_line + 1'b1),
        .fill_en   (fill_fire),
        .fill_idx  (victim_idx),
        .fill_tag  (fl_line_addr),
        .fill_data (fl_line),
        .look_hit  (look_hit),
        .look_line (look_line),
        .look_idx  (look_idx),
        .probe_hit (probe_hit),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .valid_vec (valid_vec)
    );

    lbuf_lru #(.NUM_BUF(NUM_BUF)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (lru_idx)
    );

    // Request acceptance: idle, not already replying, not during a fill cycle.
    assign fetch_done  = fl_req && fl_done;
    assign accept      = (state_q == ST_IDLE) && rd_req && !rd_ready && !fetch_done;
    assign hit_accept  = accept && buf_on && look_hit;
    assign miss_accept = accept && !(buf_on && look_hit);
    assign pf_start    = hit_accept && policy_hit_lookahead(mode_q) && !probe_hit && !fl_req;

    // Fill placement: a free entry first, else the least recently used one.
    assign fill_fire  = fetch_done && buf_on;
    assign victim_idx = free_any ? free_idx : lru_idx;
    assign touch_en   = hit_accept || fill_fire;
    assign touch_idx  = fill_fire ? victim_idx : look_idx;

    // Control sequencing of replies and the single flash fetch channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            fl_req       <= 1'b0;
            fl_line_addr <= '0;
            rd_ready     <= 1'b0;
            rd_data      <= '0;
            dem_line_q   <= '0;
            dem_word_q   <= '0;
        end else begin
            rd_ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (fetch_done) fl_req <= 1'b0;
                    if (hit_accept) begin
                        rd_ready <= 1'b1;
                        rd_data  <= look_line[req_word*WORD_W +: WORD_W];
                        if (pf_start) begin
                            fl_req       <= 1'b1;
                            fl_line_addr <= req_line + 1'b1;
                        end
                    end else if (miss_accept) begin
                        dem_line_q <= req_line;
                        dem_word_q <= req_word;
                        if (fl_req) begin
                            state_q <= ST_WAITPF;
                        end else begin
                            fl_req       <= 1'b1;
                            fl_line_addr <= req_line;
                            state_q      <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        fl_req   <= 1'b0;
                        rd_ready <= 1'b1;
                        rd_data  <= fl_line[dem_word_q*WORD_W +: WORD_W];
                        state_q  <= ST_IDLE;
                    end
                end
                ST_WAITPF: begin
                    if (fetch_done) begin
                        if (fl_line_addr == dem_line_q) begin
                            fl_req   <= 1'b0;
                            rd_ready <= 1'b1;
                            rd_data  <= fl_line[dem_word_q*WORD_W +: WORD_W];
                            state_q  <= ST_IDLE;
                        end else begin
                            fl_line_addr <= dem_line_q;
                            state_q      <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbuf_prefetch_ctrl_chk.sv
// Protocol and policy checks for lbuf_prefetch_ctrl, attached by bind.
module lbuf_prefetch_ctrl_chk #(
    parameter int TAG_W   = 12,
    parameter int NUM_BUF = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic               rd_ready,
    input logic               fl_req,
    input logic               fl_done,
    input logic [TAG_W-1:0]   fl_line_addr,
    input logic [1:0]         mode_q,
    input logic               en_q,
    input logic [NUM_BUF-1:0] valid_vec,
    input logic               hit_accept
);
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready); // R9

    AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_req)); // R9

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_done) |=> (fl_req && $stable(fl_line_addr))); // R10

    AST_DISABLE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (valid_vec == '0)); // R6

    AST_MISSONLY_NO_LOOKAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_accept && (mode_q == 2'b01) && !fl_req) |=> !fl_req); // R2

    AST_OFF_REPLY_FROM_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && ($past(mode_q) == 2'b00)) |-> $past(fl_done)); // R1
endmodule

bind lbuf_prefetch_ctrl lbuf_prefetch_ctrl_chk #(.TAG_W(TAG_W), .NUM_BUF(NUM_BUF)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_ready     (rd_ready),
    .fl_req       (fl_req),
    .fl_done      (fl_done),
    .fl_line_addr (fl_line_addr),
    .mode_q       (mode_q),
    .en_q         (en_q),
    .valid_vec    (valid_vec),
    .hit_accept   (hit_accept)
);

// File: tb/lbuf_prefetch_ctrl_tb_top.sv
// Self-checking bench: flash model with fixed latency, read tasks and
// scenario sweeps per requirement. Expected words are computed from line/word.
module lbuf_prefetch_ctrl_tb_top;
    localparam int ADDR_W = 14;
    localparam int TAG_W  = 12;
    localparam int LAT    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_pf_mode = 2'b00;
    logic              cfg_buf_en = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic [31:0]       rd_data;
    logic              fl_req;
    logic [TAG_W-1:0]  fl_line_addr;
    logic              fl_done = 1'b0;
    logic [127:0]      fl_line = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fetch_cnt = 0;
    int last_fetch_line = -1;
    int last_done_cyc = 0;
    bit f_busy = 1'b0;
    bit finished = 1'b0;

    lbuf_prefetch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pf_mode(cfg_pf_mode), .cfg_buf_en(cfg_buf_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .fl_req(fl_req), .fl_line_addr(fl_line_addr), .fl_done(fl_done), .fl_line(fl_line)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] exp_word(input int line, input int w);
        return 32'hC3A5_0000 ^ (32'(line) << 2) ^ 32'(w);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Flash model: accepts a request, answers after LAT cycles with one done pulse.
    initial begin
        int cnt = 0;
        int acc_line = 0;
        forever begin
            @(negedge clk);
            if (fl_done) begin
                fl_done = 1'b0;
            end else if (f_busy) begin
                cnt--;
                if (cnt == 0) begin
                    check(int'(fl_line_addr) == acc_line, "R10", int'(fl_line_addr), acc_line);
                    for (int w = 0; w < 4; w++) fl_line[w*32 +: 32] = exp_word(acc_line, w);
                    fl_done = 1'b1;
                    f_busy = 1'b0;
                    last_done_cyc = cyc;
                end
            end else if (fl_req) begin
                f_busy = 1'b1;
                cnt = LAT;
                acc_line = int'(fl_line_addr);
                fetch_cnt++;
                last_fetch_line = acc_line;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_idle();
        tick();
        while (fl_req || f_busy || fl_done) tick();
        tick();
    endtask

    // One read: returns data, cycles from request to reply, cycles since last fl_done.
    task automatic do_read(input int line, input int w, output logic [31:0] d,
                           output int lat, output int gap);
        int t0;
        int guard = 0;
        tick();
        rd_req = 1'b1;
        rd_addr = ADDR_W'((line << 2) | w);
        t0 = cyc;
        do begin
            tick();
            guard++;
        end while (!rd_ready && guard < 100);
        rd_req = 1'b0;
        d = rd_data;
        lat = cyc - t0;
        gap = cyc - last_done_cyc;
        tick();
        check(!rd_ready, "R9", int'(rd_ready), 0);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic e);
        tick();
        cfg_pf_mode = m;
        cfg_buf_en = e;
        tick();
    endtask

    // Read and check data; expect_fetches is the fetch count change after settling.
    task automatic read_chk(input int line, input int w, input int expect_fetches,
                            input string req);
        logic [31:0] d;
        int lat, gap, f0;
        f0 = fetch_cnt;
        do_read(line, w, d, lat, gap);
        check(d == exp_word(line, w), req, int'(d), int'(exp_word(line, w)));
        wait_idle();
        check(fetch_cnt - f0 == expect_fetches, req, fetch_cnt - f0, expect_fetches);
    endtask

    initial begin
        logic [31:0] d;
        int lat, gap, f0;

        repeat (3) tick();
        check(!rd_ready && !fl_req, "R7", int'({rd_ready, fl_req}), 0);
        rst_n = 1'b1;

        // R1: policy off, repeated reads all go to flash, reply one cycle after done.
        set_cfg(2'b00, 1'b1);
        for (int w = 0; w < 4; w++) begin
            f0 = fetch_cnt;
            do_read(5, w, d, lat, gap);
            check(d == exp_word(5, w), "R1", int'(d), int'(exp_word(5, w)));
            check(gap == 1, "R8", gap, 1);
            wait_idle();
            check(fetch_cnt - f0 == 1, "R1", fetch_cnt - f0, 1);
        end

        // R2: fill on miss, hits on all words with one-cycle latency and no fetch.
        set_cfg(2'b01, 1'b1);
        read_chk(8, 0, 1, "R2");
        for (int w = 0; w < 4; w++) begin
            f0 = fetch_cnt;
            do_read(8, w, d, lat, gap);
            check(d == exp_word(8, w), "R8", int'(d), int'(exp_word(8, w)));
            check(lat == 1, "R8", lat, 1);
            repeat (8) tick();
            check(fetch_cnt == f0, "R2", fetch_cnt - f0, 0);
        end

        // R3: look-ahead on hit targets the next line.
        set_cfg(2'b10, 1'b1);
        read_chk(8, 1, 1, "R3");
        check(last_fetch_line == 9, "R3", last_fetch_line, 9);
        read_chk(9, 2, 1, "R3");
        check(last_fetch_line == 10, "R3", last_fetch_line, 10);

        // R4: next line already held, so a hit starts nothing; a miss fetches only itself.
        read_chk(9, 0, 0, "R4");
        read_chk(20, 3, 1, "R4");
        check(last_fetch_line == 20, "R4", last_fetch_line, 20);

        // R5: miss on the line being looked ahead merges with that fetch.
        set_cfg(2'b11, 1'b1);
        f0 = fetch_cnt;
        do_read(10, 0, d, lat, gap);
        check(lat == 1, "R5", lat, 1);
        do_read(11, 3, d, lat, gap);
        check(d == exp_word(11, 3), "R5", int'(d), int'(exp_word(11, 3)));
        check(gap == 1, "R5", gap, 1);
        wait_idle();
        check(fetch_cnt - f0 == 1, "R5", fetch_cnt - f0, 1);

        // R12: miss on another line while a look-ahead runs waits and then fetches.
        f0 = fetch_cnt;
        do_read(11, 1, d, lat, gap);
        do_read(30, 2, d, lat, gap);
        check(d == exp_word(30, 2), "R12", int'(d), int'(exp_word(30, 2)));
        wait_idle();
        check(fetch_cnt - f0 == 2, "R12", fetch_cnt - f0, 2);
        check(last_fetch_line == 30, "R12", last_fetch_line, 30);

        // R11: replacement order, starting from wiped buffers.
        set_cfg(2'b01, 1'b0);
        set_cfg(2'b01, 1'b1);
        for (int l = 40; l < 44; l++) read_chk(l, 0, 1, "R11");
        read_chk(40, 1, 0, "R11");
        read_chk(44, 0, 1, "R11");
        read_chk(40, 2, 0, "R11");
        read_chk(42, 2, 0, "R11");
        read_chk(43, 2, 0, "R11");
        read_chk(41, 2, 1, "R11");

        // R6: disabled buffers answer nothing; held lines are gone after re-enable.
        set_cfg(2'b01, 1'b0);
        read_chk(40, 0, 1, "R6");
        read_chk(40, 0, 1, "R6");
        set_cfg(2'b01, 1'b1);
        read_chk(40, 3, 1, "R6");
        read_chk(40, 3, 0, "R6");

        // R7: reset forgets held lines.
        tick();
        rst_n = 1'b0;
        repeat (3) tick();
        check(!rd_ready && !fl_req, "R7", int'({rd_ready, fl_req}), 0);
        rst_n = 1'b1;
        tick();
        read_chk(40, 1, 1, "R7");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule